// File: doc/BRIEF.md
# Banked GPIO Mode and Output Controller

This block is the register side of a general-purpose pin controller for up to 64 pins. A 32-bit register bus selects, for every pin, one of eight modes held in a 3-bit field: plain input, driven output, or one of six alternate functions. Ten mode fields share one select word. The block turns each field into an output enable, an alternate-function flag and a 0 to 5 alternate index for the pad ring and the peripheral multiplexer outside it.

Output levels are never written directly. Software writes a mask to a per-bank raise word or a per-bank lower word, so several agents can change different pins without a read-modify-write. Pin inputs pass through a two-stage synchronizer and can be read back per bank of 32 pins. Reads are registered: the data appears one cycle after the read strobe.

Top module: `gpio_fsel_bank`

## Requirements
- R1: After reset every mode field is 000 (input), every output latch is 0, pinOe, pinOut and pinAltOn are all zero and regRdata is zero.
- R2: The mode field of pin n sits in the word at byte address 4*(n/10), bits (n mod 10)*3 up to (n mod 10)*3+2, and reads back as written; bits 30 and 31, and fields of pins at or above PIN_COUNT, read as zero.
- R3: A field of 001 makes that pin's pinOe high; any other value keeps it low, and 000 leaves both pinOe and pinAltOn low.
- R4: Field codes 100, 101, 110, 111, 011 and 010 raise pinAltOn with pinAltIdx 0, 1, 2, 3, 4 and 5; for codes 000 and 001 pinAltIdx is 0.
- R5: A write to byte address 0x1C + 4*bank sets the output latch of pin bank*32+b for each 1 in bit b, leaves latches under 0 bits unchanged, and pinOut shows it one cycle after the write.
- R6: A write to byte address 0x28 + 4*bank clears the latch of pin bank*32+b for each 1 in bit b and leaves the others unchanged, visible one cycle after the write.
- R7: Reads of the raise and lower words return zero.
- R8: Byte address 0x34 + 4*bank returns the synchronized level of pins bank*32 to bank*32+31 (zero above PIN_COUNT); a pinIn change before a clock edge is returned by a read strobed on the third edge after it, not earlier; writes there change nothing.
- R9: regRdata takes a new value only on a clock edge where regRead is high and holds otherwise.
- R10: Unmapped or unaligned addresses (including select words beyond the implemented pins and level words beyond the implemented banks) read as zero and ignore writes.
- R11: pinOut follows only the latch: changing a pin's mode leaves its latch value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 8 | Byte address of the register access |
| regWrite | input | 1 | Write strobe, one cycle per write |
| regRead | input | 1 | Read strobe, data returned one cycle later |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Registered read data |
| pinIn | input | PIN_COUNT | Asynchronous pin levels |
| pinOut | output | PIN_COUNT | Output latch per pin |
| pinOe | output | PIN_COUNT | Output enable per pin (mode 001) |
| pinAltOn | output | PIN_COUNT | Pin is handed to an alternate function |
| pinAltIdx | output | 3*PIN_COUNT | Alternate function index per pin, 3 bits each |

## Verification
Mode decodes and output latches change on the edge that takes the write, so pinOe, pinAltOn, pinAltIdx and pinOut are due one cycle after the strobe; read data is due on the edge that takes regRead, and a pin level needs two synchronizer edges before a read can pick it up, so it is returned by the read taken on the third edge. The bench steps a behavioural model on every rising edge with these same delays and compares all outputs on the falling edge, where nothing is changing. Directed reads issued back to back right after a pin change check that the old level is returned twice before the new one appears.

// File: rtl/gpio_fsel_pkg.sv
package gpio_fsel_pkg;

  localparam int MAX_SEL  = 7;
  localparam int MAX_BANK = 2;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 32;

  localparam logic [5:0] SEL_WORD = 6'd0;
  localparam logic [5:0] SET_WORD = 6'd7;
  localparam logic [5:0] CLR_WORD = 6'd10;
  localparam logic [5:0] LEV_WORD = 6'd13;

  typedef enum logic [2:0] {
    FN_IN   = 3'b000,
    FN_OUT  = 3'b001,
    FN_ALT5 = 3'b010,
    FN_ALT4 = 3'b011,
    FN_ALT0 = 3'b100,
    FN_ALT1 = 3'b101,
    FN_ALT2 = 3'b110,
    FN_ALT3 = 3'b111
  } pinFn_e;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_SEL  = 2'd1,
    RD_LEV  = 2'd2
  } rdKind_e;

  typedef struct packed {
    logic [MAX_SEL-1:0]  selWr;
    logic [MAX_BANK-1:0] setWr;
    logic [MAX_BANK-1:0] clrWr;
    logic                rdEn;
    rdKind_e             rdKind;
    logic [2:0]          rdIdx;
  } strobe_t;

  function automatic logic [2:0] altIndex(input logic [2:0] fn);
    case (fn)
      FN_ALT0: altIndex = 3'd0;
      FN_ALT1: altIndex = 3'd1;
      FN_ALT2: altIndex = 3'd2;
      FN_ALT3: altIndex = 3'd3;
      FN_ALT4: altIndex = 3'd4;
      FN_ALT5: altIndex = 3'd5;
      default: altIndex = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/gpio_fsel_ctrl.sv
module gpio_fsel_ctrl
  import gpio_fsel_pkg::*;
#(
  parameter int NUM_SEL  = 6,
  parameter int NUM_BANK = 2
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrite,
  input  logic              regRead,
  output strobe_t           stb
);

  logic       aligned;
  logic [5:0] word;

  assign aligned = (regAddr[1:0] == 2'b00);
  assign word    = regAddr[ADDR_W-1:2];

  always_comb begin
    stb        = '0;
    stb.rdKind = RD_ZERO;
    stb.rdEn   = regRead;
    if (aligned) begin
      for (int r = 0; r < NUM_SEL; r++) begin
        if (word == SEL_WORD + 6'(r)) begin
          stb.selWr[r] = regWrite;
          if (regRead) begin
            stb.rdKind = RD_SEL;
            stb.rdIdx  = 3'(r);
          end
        end
      end
      for (int b = 0; b < NUM_BANK; b++) begin
        if (word == SET_WORD + 6'(b)) stb.setWr[b] = regWrite;
        if (word == CLR_WORD + 6'(b)) stb.clrWr[b] = regWrite;
        if (word == LEV_WORD + 6'(b) && regRead) begin
          stb.rdKind = RD_LEV;
          stb.rdIdx  = 3'(b);
        end
      end
    end
  end

endmodule

// File: rtl/gpio_fsel_dp.sv
module gpio_fsel_dp
  import gpio_fsel_pkg::*;
#(
  parameter int PIN_COUNT = 54,
  parameter int NUM_SEL   = 6,
  parameter int NUM_BANK  = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                stb,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [PIN_COUNT-1:0]   pinIn,
  output logic [DATA_W-1:0]      rdata,
  output logic [PIN_COUNT-1:0]   pinOut,
  output logic [PIN_COUNT-1:0]   pinOe,
  output logic [PIN_COUNT-1:0]   pinAltOn,
  output logic [3*PIN_COUNT-1:0] pinAltIdx
);

  localparam int LEV_W = NUM_BANK * 32;

  logic [2:0]           fieldArr [PIN_COUNT];
  logic [PIN_COUNT-1:0] syncA, syncB;
  logic [LEV_W-1:0]     levPad;
  logic [DATA_W-1:0]    selImg [NUM_SEL];
  logic [DATA_W-1:0]    rdNext;
  logic                 unusedStb;

  assign unusedStb = ^{stb.selWr, stb.setWr, stb.clrWr, stb.rdIdx};

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    localparam int SelR    = p / 10;
    localparam int FieldLo = (p % 10) * 3;
    localparam int BankB   = p / 32;
    localparam int BitB    = p % 32;

    logic [2:0] fieldQ;
    logic       outQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   fieldQ <= FN_IN;
      else if (stb.selWr[SelR])    fieldQ <= wdata[FieldLo +: 3];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                  outQ <= 1'b0;
      else if (stb.setWr[BankB] && wdata[BitB])   outQ <= 1'b1;
      else if (stb.clrWr[BankB] && wdata[BitB])   outQ <= 1'b0;
    end

    assign fieldArr[p]         = fieldQ;
    assign pinOut[p]           = outQ;
    assign pinOe[p]            = (fieldQ == FN_OUT);
    assign pinAltOn[p]         = fieldQ[2] | fieldQ[1];
    assign pinAltIdx[3*p +: 3] = altIndex(fieldQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
    end
  end

  assign levPad = LEV_W'(syncB);

  always_comb begin
    for (int r = 0; r < NUM_SEL; r++) selImg[r] = '0;
    for (int p = 0; p < PIN_COUNT; p++) selImg[p/10][(p%10)*3 +: 3] = fieldArr[p];
  end

  always_comb begin
    rdNext = '0;
    case (stb.rdKind)
      RD_SEL: begin
        for (int r = 0; r < NUM_SEL; r++)
          if (stb.rdIdx == 3'(r)) rdNext = selImg[r];
      end
      RD_LEV: begin
        for (int b = 0; b < NUM_BANK; b++)
          if (stb.rdIdx == 3'(b)) rdNext = levPad[b*32 +: 32];
      end
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdata <= '0;
    else if (stb.rdEn)  rdata <= rdNext;
  end

endmodule

// File: rtl/gpio_fsel_bank.sv
module gpio_fsel_bank
  import gpio_fsel_pkg::*;
#(
  parameter int PIN_COUNT = 54
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [7:0]             regAddr,
  input  logic                   regWrite,
  input  logic                   regRead,
  input  logic [31:0]            regWdata,
  output logic [31:0]            regRdata,
  input  logic [PIN_COUNT-1:0]   pinIn,
  output logic [PIN_COUNT-1:0]   pinOut,
  output logic [PIN_COUNT-1:0]   pinOe,
  output logic [PIN_COUNT-1:0]   pinAltOn,
  output logic [3*PIN_COUNT-1:0] pinAltIdx
);

  localparam int NUM_SEL  = (PIN_COUNT + 9) / 10;
  localparam int NUM_BANK = (PIN_COUNT + 31) / 32;

  strobe_t stb;

  gpio_fsel_ctrl #(
    .NUM_SEL  (NUM_SEL),
    .NUM_BANK (NUM_BANK)
  ) u_ctrl (
    .regAddr  (regAddr),
    .regWrite (regWrite),
    .regRead  (regRead),
    .stb      (stb)
  );

  gpio_fsel_dp #(
    .PIN_COUNT (PIN_COUNT),
    .NUM_SEL   (NUM_SEL),
    .NUM_BANK  (NUM_BANK)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wdata     (regWdata),
    .pinIn     (pinIn),
    .rdata     (regRdata),
    .pinOut    (pinOut),
    .pinOe     (pinOe),
    .pinAltOn  (pinAltOn),
    .pinAltIdx (pinAltIdx)
  );

endmodule

// File: rtl/gpio_fsel_bank_chk.sv
module gpio_fsel_bank_chk #(
  parameter int PIN_COUNT = 54
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [7:0]           regAddr,
  input logic                 regWrite,
  input logic                 regRead,
  input logic [31:0]          regWdata,
  input logic [31:0]          regRdata,
  input logic [PIN_COUNT-1:0] pinOut,
  input logic [PIN_COUNT-1:0] pinOe,
  input logic [PIN_COUNT-1:0] pinAltOn
);

  localparam int B0W = (PIN_COUNT < 32) ? PIN_COUNT : 32;

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && regAddr == 8'h1C) |=>
      ((pinOut[B0W-1:0] & $past(regWdata[B0W-1:0])) == $past(regWdata[B0W-1:0]))); // R5

  AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && regAddr == 8'h28) |=>
      ((pinOut[B0W-1:0] & $past(regWdata[B0W-1:0])) == '0)); // R6

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !regWrite |=> $stable(pinOut)); // R11

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !regWrite |=> ($stable(pinOe) && $stable(pinAltOn))); // R2

  AST_OE_ALT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    (pinOe & pinAltOn) == '0); // R4

  AST_SETCLR_RD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regRead && (regAddr == 8'h1C || regAddr == 8'h20 ||
                 regAddr == 8'h28 || regAddr == 8'h2C)) |=> (regRdata == '0)); // R7

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !regRead |=> $stable(regRdata)); // R9

endmodule

bind gpio_fsel_bank gpio_fsel_bank_chk #(.PIN_COUNT(PIN_COUNT)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regAddr  (regAddr),
  .regWrite (regWrite),
  .regRead  (regRead),
  .regWdata (regWdata),
  .regRdata (regRdata),
  .pinOut   (pinOut),
  .pinOe    (pinOe),
  .pinAltOn (pinAltOn)
);

// File: tb/gpio_fsel_bank_test.sv
`timescale 1ns/100ps
module gpio_fsel_bank_test;

  localparam int PIN_COUNT = 54;
  localparam int NSEL      = (PIN_COUNT + 9) / 10;
  localparam int NBANK     = (PIN_COUNT + 31) / 32;

  logic                   clk = 1'b0;
  logic                   rstN = 1'b0;
  logic [7:0]             regAddr = '0;
  logic                   regWrite = 1'b0;
  logic                   regRead = 1'b0;
  logic [31:0]            regWdata = '0;
  logic [31:0]            regRdata;
  logic [PIN_COUNT-1:0]   pinIn = '0;
  logic [PIN_COUNT-1:0]   pinOut, pinOe, pinAltOn;
  logic [3*PIN_COUNT-1:0] pinAltIdx;

  int testsRun = 0;
  int testsFailed = 0;

  gpio_fsel_bank #(.PIN_COUNT(PIN_COUNT)) uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrite(regWrite),
    .regRead(regRead), .regWdata(regWdata), .regRdata(regRdata),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .pinAltOn(pinAltOn),
    .pinAltIdx(pinAltIdx)
  );

  always #2.5 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int                   mFn [PIN_COUNT];
  logic [PIN_COUNT-1:0] mLatch, mS1, mS2;
  logic [31:0]          mRd;

  function automatic logic [31:0] mReadWord(input logic [7:0] a);
    int w;
    logic [31:0] v;
    v = '0;
    w = int'(a) / 4;
    if (a[1:0] != 2'b00) return '0;
    if (w < NSEL) begin
      for (int k = 0; k < 10; k++)
        if (w*10 + k < PIN_COUNT) v[3*k +: 3] = 3'(mFn[w*10 + k]);
    end else if (w >= 13 && w < 13 + NBANK) begin
      for (int i = 0; i < 32; i++)
        if ((w-13)*32 + i < PIN_COUNT) v[i] = mS2[(w-13)*32 + i];
    end
    return v;
  endfunction

  task automatic mWriteWord(input logic [7:0] a, input logic [31:0] d);
    int w;
    w = int'(a) / 4;
    if (a[1:0] != 2'b00) return;
    if (w < NSEL) begin
      for (int k = 0; k < 10; k++)
        if (w*10 + k < PIN_COUNT) mFn[w*10 + k] = int'(d[3*k +: 3]);
    end else if (w >= 7 && w < 7 + NBANK) begin
      for (int i = 0; i < 32; i++)
        if ((w-7)*32 + i < PIN_COUNT && d[i]) mLatch[(w-7)*32 + i] = 1'b1;
    end else if (w >= 10 && w < 10 + NBANK) begin
      for (int i = 0; i < 32; i++)
        if ((w-10)*32 + i < PIN_COUNT && d[i]) mLatch[(w-10)*32 + i] = 1'b0;
    end
  endtask

  initial begin
    for (int p = 0; p < PIN_COUNT; p++) mFn[p] = 0;
    mLatch = '0; mS1 = '0; mS2 = '0; mRd = '0;
  end

  always @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < PIN_COUNT; p++) mFn[p] = 0;
      mLatch = '0; mS1 = '0; mS2 = '0; mRd = '0;
    end else begin
      if (regRead) mRd = mReadWord(regAddr);
      mS2 = mS1;
      mS1 = pinIn;
      if (regWrite) mWriteWord(regAddr, regWdata);
    end
  end

  task automatic check(input string tag, input logic [191:0] act, input logic [191:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (rstN) begin
      logic [PIN_COUNT-1:0]   eOe, eAlt;
      logic [3*PIN_COUNT-1:0] eIdx;
      for (int p = 0; p < PIN_COUNT; p++) begin
        eOe[p]  = (mFn[p] == 1);
        eAlt[p] = (mFn[p] >= 2);
        eIdx[3*p +: 3] = (mFn[p] >= 4) ? 3'(mFn[p] - 4) : (mFn[p] >= 2 ? 3'(7 - mFn[p]) : 3'd0);
      end
      check("R5/R6 pinOut", 192'(pinOut), 192'(mLatch));
      check("R3 pinOe", 192'(pinOe), 192'(eOe));
      check("R4 pinAltOn", 192'(pinAltOn), 192'(eAlt));
      check("R4 pinAltIdx", 192'(pinAltIdx), 192'(eIdx));
      check("R9 regRdata", 192'(regRdata), 192'(mRd));
    end
  end

  // ---------------- stimulus ----------------
  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    regAddr = a; regWdata = d; regWrite = 1'b1;
    @(negedge clk);
    regWrite = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, input logic [31:0] exp, input string tag);
    regAddr = a; regRead = 1'b1;
    @(negedge clk);
    regRead = 1'b0;
    check(tag, 192'(regRdata), 192'(exp));
  endtask

  localparam logic [PIN_COUNT-1:0] PAT = 54'h2B_1234_8765_4321;

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pinOut", 192'(pinOut), 192'(0));
    check("R1 pinOe", 192'(pinOe), 192'(0));
    check("R1 pinAltOn", 192'(pinAltOn), 192'(0));
    check("R1 regRdata", 192'(regRdata), 192'(0));
    busRead(8'h00, 32'h0, "R1 select word 0");

    // R2/R3/R4 modes on pins 0..7
    busWrite(8'h00, 32'hC009_FD61);
    @(negedge clk);
    busRead(8'h00, 32'h0009_FD61, "R2 select readback");
    check("R3 oe pin0 only", 192'(pinOe[7:0]), 192'(8'h01));
    check("R4 alt flags", 192'(pinAltOn[7:0]), 192'(8'h7E));
    check("R4 alt0", 192'(pinAltIdx[3 +: 3]), 192'(0));
    check("R4 alt1", 192'(pinAltIdx[6 +: 3]), 192'(1));
    check("R4 alt2", 192'(pinAltIdx[9 +: 3]), 192'(2));
    check("R4 alt3", 192'(pinAltIdx[12 +: 3]), 192'(3));
    check("R4 alt4", 192'(pinAltIdx[15 +: 3]), 192'(4));
    check("R4 alt5", 192'(pinAltIdx[18 +: 3]), 192'(5));
    busWrite(8'h14, 32'hFFFF_FFFF);
    busRead(8'h14, 32'h0000_0FFF, "R2 last word partial");

    // R5/R6 set and clear
    busWrite(8'h1C, 32'h0000_00F0);
    check("R5 set F0", 192'(pinOut[7:0]), 192'(8'hF0));
    busWrite(8'h1C, 32'h0000_0001);
    check("R5 set or", 192'(pinOut[7:0]), 192'(8'hF1));
    busWrite(8'h28, 32'h0000_0030);
    check("R6 clear", 192'(pinOut[7:0]), 192'(8'hC1));
    busWrite(8'h28, 32'h0000_0000);
    check("R6 zero mask", 192'(pinOut[7:0]), 192'(8'hC1));
    busWrite(8'h20, 32'hFFFF_FFFF);
    check("R5 bank1", 192'(pinOut[53:32]), 192'(22'h3F_FFFF));
    busRead(8'h1C, 32'h0, "R7 set reads zero");
    busRead(8'h2C, 32'h0, "R7 clear reads zero");

    // R11 mode change leaves latch alone
    busWrite(8'h00, 32'h0);
    check("R11 latch kept", 192'(pinOut[7:0]), 192'(8'hC1));
    check("R11 oe dropped", 192'(pinOe[0]), 192'(0));

    // R8 level readback and latency
    pinIn = PAT;
    @(negedge clk); @(negedge clk);
    busRead(8'h34, PAT[31:0], "R8 level bank0");
    busRead(8'h38, 32'(PAT[53:32]), "R8 level bank1");
    busWrite(8'h34, 32'h0);
    busRead(8'h34, PAT[31:0], "R8 write ignored");
    pinIn = ~PAT;
    busRead(8'h34, PAT[31:0], "R8 latency edge1");
    busRead(8'h34, PAT[31:0], "R8 latency edge2");
    busRead(8'h34, 32'h789A_BCDE, "R8 latency edge3");

    // R10 unmapped
    busWrite(8'h18, 32'hFFFF_FFFF);
    busRead(8'h18, 32'h0, "R10 select beyond pins");
    busWrite(8'h40, 32'hFFFF_FFFF);
    busRead(8'h40, 32'h0, "R10 far address");
    busRead(8'h3C, 32'h0, "R10 level beyond banks");
    busRead(8'h01, 32'h0, "R10 unaligned");

    // R9 hold
    repeat (3) @(negedge clk);
    check("R9 hold", 192'(regRdata), 192'(0));

    // mixed traffic, checked every cycle by the model
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] a;
      int pick;
      pick = int'($urandom % 14);
      a = (pick < 8) ? 8'(pick * 4) :
          (pick == 8) ? 8'h1C : (pick == 9) ? 8'h20 :
          (pick == 10) ? 8'h28 : (pick == 11) ? 8'h2C :
          (pick == 12) ? 8'h34 : 8'h38;
      if ($urandom % 4 == 0) pinIn = {$urandom, $urandom};
      regAddr  = a;
      regWdata = $urandom;
      regWrite = ($urandom % 2 == 0);
      regRead  = ($urandom % 2 == 0);
      @(negedge clk);
    end
    regWrite = 1'b0; regRead = 1'b0;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule